// File: doc/BRIEF.md
# Streaming Bit-Reversal Reorder Buffer

This block turns a continuous stream of fixed-length frames between natural sample order and bit-reversed sample order, as needed in front of or behind a radix-2 FFT. It keeps a single RAM of `N` words. On every accepted input sample the addressed word is read first, and the new sample then goes into the same word. The address is taken either from a log2(N)-bit counter as it stands or from the same counter with its bits mirrored. The choice flips each time the counter wraps, and the first frame after reset uses the plain count.

Because each new sample lands exactly where the previous frame's sample has just been read out, the buffer never needs a second bank. After the first frame has been written, one sample leaves for every sample that arrives. Output frame k+1 carries input frame k in bit-reversed order. Since bit reversal is its own inverse, the same block serves both directions. A small controller with two states tracks whether the buffer holds a full frame yet. `ST_FILL` is entered on reset and moves to `ST_STREAM` when the N-th sample is accepted (transition "fill done"). `ST_STREAM` holds until reset (transition "reset to fill").

Top module: `bitrev_reorder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the design clears `out_valid` at that edge, clears the address counter and selects the plain (non-reversed) address mode.
- R2: For the first N accepted samples after reset, `out_valid` stays low.
- R3: Once N samples have been accepted, each sample accepted at edge t produces `out_valid` high after edge t, and `out_data` for position j (0-based) of a frame equals the input sample at position bitrev(j) of the previous frame. bitrev(j) mirrors the log2(N) index bits, so position 1 maps to N/2.
- R4: The address mode alternates at every frame boundary. Across consecutive frames the output is continuous: one valid sample per accepted sample, with both frame parities ordered as in R3.
- R5: A clock with `in_valid` low writes nothing, leaves the counter and mode unchanged, and gives `out_valid` low after that edge. The stream then resumes as if the idle cycle had not occurred.
- R6: A reset during a frame discards the partial frame. The next N samples give no valid output, and the frame after them outputs those N samples bit-reversed.
- R7: The behaviour of R2 to R5 holds for any power-of-two N ≥ 2, including N = 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | DW | Input sample |
| out_valid | output | 1 | `out_data` carries a reordered sample |
| out_data | output | DW | Reordered sample, one cycle after its slot's input |

## Verification
Every cycle, the assertions check three things: the mode flips exactly at a counter wrap, and the counter and mode freeze on idle cycles. `out_valid` is tied to a sample count kept independently in the checker, so it is never high before N samples and always high once they are in. They also check the reset values. Only the bench's directed scenarios can show that the data is right. That covers the bit-reversed order in both the plain and the mirrored address phases, resumption after gaps, discarding a partial frame on reset, and the 64-point instance.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

    // Controller states: buffer not yet holding a whole frame, or streaming.
    typedef enum logic {
        ST_FILL   = 1'b0,
        ST_STREAM = 1'b1
    } rbr_state_e;

    // Address mode: counter used as is, or with its bits mirrored.
    typedef enum logic {
        MODE_SEQ = 1'b0,
        MODE_REV = 1'b1
    } rbr_mode_e;

endpackage

// File: rtl/rbr_addr_gen.sv
module rbr_addr_gen
    import rbr_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] cnt,
    output rbr_mode_e     mode,
    output logic          wrap
);

    localparam logic [AW-1:0] LAST = AW'(N - 1);

    logic [AW-1:0] cnt_q;
    rbr_mode_e     mode_q;
    logic [AW-1:0] cnt_rev;

    // Mirrored counter: fixed wiring, no logic.
    generate
        for (genvar g = 0; g < AW; g++) begin : g_mirror
            assign cnt_rev[g] = cnt_q[AW-1-g];
        end
    endgenerate

    assign wrap = adv && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= MODE_SEQ;
        end else if (adv) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + AW'(1);
            if (cnt_q == LAST) begin
                mode_q <= (mode_q == MODE_SEQ) ? MODE_REV : MODE_SEQ;
            end
        end
    end

    // Two-way selector on the counter output.
    always_comb begin
        unique case (mode_q)
            MODE_SEQ: addr = cnt_q;
            MODE_REV: addr = cnt_rev;
            default:  addr = cnt_q;
        endcase
    end

    assign cnt  = cnt_q;
    assign mode = mode_q;

endmodule

// File: rtl/rbr_ram.sv
module rbr_ram #(
    parameter int N  = 8,
    parameter int DW = 16,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [N];
    logic [DW-1:0] rdata_q;

    // Synchronous read-before-write on one address: the read register takes
    // the old contents while the same location is overwritten.
    always_ff @(posedge clk) begin
        if (en) begin
            rdata_q   <= mem[addr];
            mem[addr] <= wdata;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/rbr_ctrl.sv
module rbr_ctrl
    import rbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       wrap,
    output logic       out_valid,
    output rbr_state_e state
);

    rbr_state_e state_q;
    rbr_state_e state_d;
    logic       out_valid_q;

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:   if (wrap) state_d = ST_STREAM;   // fill done
            ST_STREAM: state_d = ST_STREAM;
            default:   state_d = ST_FILL;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;                          // reset to fill
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: valid follows an accepted sample once a frame is stored.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FILL:   out_valid_q <= 1'b0;
                ST_STREAM: out_valid_q <= in_valid;
                default:   out_valid_q <= 1'b0;
            endcase
        end
    end

    assign out_valid = out_valid_q;
    assign state     = state_q;

endmodule

// File: rtl/bitrev_reorder.sv
module bitrev_reorder
    import rbr_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    localparam int AW = (N > 1) ? $clog2(N) : 1;

    logic [AW-1:0] addr_w;
    logic [AW-1:0] cnt_w;
    rbr_mode_e     mode_w;
    logic          wrap_w;
    rbr_state_e    state_w;

    rbr_addr_gen #(.N(N), .AW(AW)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .adv  (in_valid),
        .addr (addr_w),
        .cnt  (cnt_w),
        .mode (mode_w),
        .wrap (wrap_w)
    );

    rbr_ram #(.N(N), .DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .en    (in_valid),
        .addr  (addr_w),
        .wdata (in_data),
        .rdata (out_data)
    );

    rbr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .wrap      (wrap_w),
        .out_valid (out_valid),
        .state     (state_w)
    );

endmodule

// File: rtl/rbr_chk.sv
module rbr_chk
    import rbr_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          out_valid,
    input logic [AW-1:0] cnt,
    input rbr_mode_e     mode
);

    localparam logic [AW-1:0] LAST = AW'(N - 1);
    localparam logic [AW:0]   FULL = (AW + 1)'(N);

    // Samples accepted since reset, saturating at N.
    logic [AW:0] seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= '0;
        else if (in_valid && seen != FULL) seen <= seen + 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && cnt == '0 && mode == MODE_SEQ));

    // R2
    no_early_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen == FULL));

    // R3
    valid_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && seen == FULL) |=> out_valid);

    // R4
    mode_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnt == LAST) |=> (mode != $past(mode)));

    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnt != LAST) |=> $stable(mode));

    // R5
    idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(cnt) && $stable(mode) && !out_valid));

endmodule

bind bitrev_reorder rbr_chk #(.N(N), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .cnt       (cnt_w),
    .mode      (mode_w)
);

// File: tb/sim_bitrev_reorder.sv
`timescale 1ns/1ps
module sim_bitrev_reorder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iv0 = 1'b0, iv1 = 1'b0;
    logic [15:0] id0 = '0,   id1 = '0;
    logic        ov0, ov1;
    logic [15:0] od0, od1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    bitrev_reorder #(.N(8),  .DW(16)) u0 (
        .clk(clk), .rst(rst), .in_valid(iv0), .in_data(id0),
        .out_valid(ov0), .out_data(od0));

    bitrev_reorder #(.N(64), .DW(16)) u1 (
        .clk(clk), .rst(rst), .in_valid(iv1), .in_data(id1),
        .out_valid(ov1), .out_data(od1));

    // Reference models: previous frame, current frame, position, fill flag.
    logic [15:0] p8 [8];
    logic [15:0] c8 [8];
    int          i8 = 0;
    bit          f8 = 0;
    logic [15:0] p64 [64];
    logic [15:0] c64 [64];
    int          i64 = 0;
    bit          f64 = 0;

    function automatic int brev(input int v, input int w);
        int r = 0;
        for (int b = 0; b < w; b++) if (v[b]) r |= (1 << (w - 1 - b));
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle on the 8-point instance and check the result one edge later.
    task automatic push8(input bit v, input logic [15:0] d, input string req);
        bit          ev;
        logic [15:0] ed;
        iv0 = v; id0 = d;
        ev = v && f8;
        ed = p8[brev(i8, 3)];
        if (v) begin
            c8[i8] = d;
            i8++;
            if (i8 == 8) begin p8 = c8; i8 = 0; f8 = 1; end
        end
        @(negedge clk);
        chk(ov0 == ev, req, "u0 out_valid", int'(ov0), int'(ev));
        if (ev) chk(od0 == ed, req, "u0 out_data", int'(od0), int'(ed));
    endtask

    task automatic push64(input bit v, input logic [15:0] d, input string req);
        bit          ev;
        logic [15:0] ed;
        iv1 = v; id1 = d;
        ev = v && f64;
        ed = p64[brev(i64, 6)];
        if (v) begin
            c64[i64] = d;
            i64++;
            if (i64 == 64) begin p64 = c64; i64 = 0; f64 = 1; end
        end
        @(negedge clk);
        chk(ov1 == ev, req, "u1 out_valid", int'(ov1), int'(ev));
        if (ev) chk(od1 == ed, req, "u1 out_data", int'(od1), int'(ed));
    endtask

    task automatic t_reset(input string req);
        rst = 1'b1; iv0 = 1'b0; iv1 = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(ov0 == 1'b0, req, "u0 out_valid in reset", int'(ov0), 0);
        chk(ov1 == 1'b0, req, "u1 out_valid in reset", int'(ov1), 0);
        i8 = 0; f8 = 0; i64 = 0; f64 = 0;
        rst = 1'b0;
    endtask

    task automatic t_fill();
        for (int k = 0; k < 8; k++) push8(1'b1, 16'h1000 + 16'(k), "R2");
    endtask

    task automatic t_stream();
        for (int k = 0; k < 8; k++) push8(1'b1, 16'h2000 + 16'(k * 3), "R3");
        for (int k = 0; k < 8; k++) push8(1'b1, 16'h3F00 - 16'(k), "R4");
        for (int k = 0; k < 8; k++) push8(1'b1, 16'h5A5A ^ 16'(k << 4), "R4");
    endtask

    task automatic t_gaps();
        for (int k = 0; k < 16; k++) begin
            push8(1'b1, 16'h7000 + 16'(k), "R5");
            if (k % 3 == 0) push8(1'b0, 16'hDEAD, "R5");
            if (k == 7) begin
                push8(1'b0, 16'hBEEF, "R5");
                push8(1'b0, 16'hBEEF, "R5");
            end
        end
    endtask

    task automatic t_reset_mid();
        for (int k = 0; k < 5; k++) push8(1'b1, 16'h8800 + 16'(k), "R6");
        t_reset("R6");
        for (int k = 0; k < 8; k++) push8(1'b1, 16'h9100 + 16'(k), "R6");
        for (int k = 0; k < 8; k++) push8(1'b1, 16'h9200 + 16'(k), "R6");
        push8(1'b0, 16'h0, "R6");
    endtask

    task automatic t_n64();
        for (int f = 0; f < 4; f++) begin
            for (int k = 0; k < 64; k++) begin
                push64(1'b1, 16'(f * 256 + k * 5), "R7");
                if (f == 2 && k == 30) push64(1'b0, 16'h0, "R7");
            end
        end
        push64(1'b0, 16'h0, "R7");
    endtask

    initial begin
        @(negedge clk);
        t_reset("R1");
        t_fill();
        t_stream();
        t_gaps();
        t_reset_mid();
        t_n64();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule